// File: doc/BRIEF.md
# LPC Peripheral Target Bridge

This block sits on the peripheral side of a Low Pin Count bus. It watches the host's frame strobe and the 4-bit multiplexed bus, and decodes I/O, memory and firmware cycles in both directions. Each decoded cycle becomes one request on a simple local register port. The request carries the address space, the direction, the address, the byte size and the write data. The local side answers with ready, error and read data. The bridge drives the bus only in its own phases: the sync field, the read data and its own turnaround. A separate output enable stands in for the tristate buffer.

While the local port has not answered, the bridge drives wait-state sync codes. It starts with short waits and switches to long waits after a set number of clocks. If no answer arrives within a parameterized limit, it reports an error sync. An error ends the transfer: read data is skipped and the bridge goes straight to its turnaround. If the host asserts the frame strobe while a transaction is in progress, the bridge aborts that transaction and releases the bus.

The state machine has these states: IDLE, CTYPE (cycle type nibble), ADDR (address nibbles), SIZE (firmware size nibble), HDATA (host write data), HTAR1/HTAR2 (host turnaround), SYNC (wait codes, request outstanding), SYNC_END (ready or error code), TDATA (target read data), TTAR1/TTAR2 (target turnaround). The transitions are:
- IDLE to CTYPE on a standard start, or IDLE to ADDR on a firmware start.
- CTYPE to ADDR on a valid cycle type, otherwise to IDLE.
- ADDR, after its last nibble, to SIZE (firmware), HDATA (write) or HTAR1 (read).
- SIZE to HDATA or HTAR1, or to IDLE on an unsupported size.
- HDATA to HTAR1 after the last data nibble.
- HTAR1 to HTAR2, then HTAR2 to SYNC.
- SYNC to SYNC_END on a local answer or a timeout.
- SYNC_END to TDATA for a successful read, otherwise to TTAR1.
- TDATA to TTAR1 after the last data nibble.
- TTAR1 to TTAR2, then TTAR2 to IDLE.
- Any state other than IDLE goes to IDLE when the frame strobe is asserted.

Top module: `lpc_target_bridge`

## Requirements
- R1: With `frame_i` high in IDLE, the start nibble 0000 opens an I/O or memory cycle, 1101 a firmware read and 1110 a firmware write. Any other start nibble is ignored. `req_space` reads 0 for I/O, 1 for memory and 2 for firmware.
- R2: In a standard cycle the nibble after the start is {0, memory, write, 0}, and this sets `req_space` and `req_write`. A nibble with bit 3 or bit 0 set is unsupported: the cycle is dropped, and no request or bus drive follows.
- R3: Address nibbles arrive most significant first. An I/O cycle carries 4 nibbles, and `req_addr` holds them zero-extended. Memory and firmware cycles carry 8 nibbles.
- R4: A firmware cycle carries a size nibble after the address: 0, 1 or 2 gives `req_size` 0, 1 or 2 (1, 2 or 4 bytes). A size nibble of 3 or more drops the cycle. I/O and memory cycles always have `req_size` 0.
- R5: Write data arrives least significant nibble first, with bytes in ascending order and back to back. `req_wdata` bits beyond the transfer size are zero, and reads present zero.
- R6: The host's turnaround takes two clocks, and `bus_oe` stays low through every host phase of a cycle.
- R7: `req_valid` is high in every sync wait clock and falls one clock after `rsp_ready` is seen or the limit expires. While it is high and unanswered, the request fields hold steady.
- R8: In sync wait clock k (counting from 0), the bridge drives 0101 while k < LONG_AFTER and 0110 after that. The clock after a ready answer drives 0000.
- R9: An answer with `rsp_error` drives 1010 in place of the ready code. The bridge then skips any read data and enters its turnaround on the next clock.
- R10: If WAIT_LIMIT sync wait clocks pass without an answer, the bridge drops `req_valid` and drives 1010.
- R11: After a ready code on a read, the bridge drives `rsp_rdata` as 2, 4 or 8 nibbles (for size 0, 1 or 2), least significant nibble first.
- R12: The target turnaround drives 1111 for one clock and then releases the bus. Two clocks after the 1111 clock, the bridge is idle.
- R13: If `frame_i` is asserted in any state other than IDLE, the next clock has `bus_oe` and `req_valid` low and the bridge is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Host frame strobe, active high |
| bus_in | input | 4 | Nibble sampled from the bus |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | Target drives the bus when high |
| req_valid | output | 1 | Local request outstanding |
| req_write | output | 1 | Request is a write |
| req_space | output | 2 | 0 I/O, 1 memory, 2 firmware |
| req_addr | output | 32 | Request address |
| req_size | output | 2 | Byte count code: 0, 1 or 2 for 1, 2 or 4 bytes |
| req_wdata | output | 32 | Write data, low byte first |
| rsp_ready | input | 1 | Local side answers the request |
| rsp_error | input | 1 | Answer is an error (with rsp_ready) |
| rsp_rdata | input | 32 | Read data (with rsp_ready) |

## Verification
The bench builds the bridge with WAIT_LIMIT set to 12 and LONG_AFTER set to 4. With these values, the switch from short to long wait codes appears after only a few held clocks, and the timeout error appears after a dozen. All of this fits next to cycles of every space, direction and firmware size. Aborts in mid-address and in mid-sync, and dropped cycles from bad start, type or size nibbles, are each followed by a normal cycle. This shows that the bridge recovers from each of them.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    localparam int NIB_W  = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    localparam logic [NIB_W-1:0] START_STD   = 4'b0000;
    localparam logic [NIB_W-1:0] START_FW_RD = 4'b1101;
    localparam logic [NIB_W-1:0] START_FW_WR = 4'b1110;

    localparam logic [NIB_W-1:0] SYNC_READY = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_SHORT = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_LONG  = 4'b0110;
    localparam logic [NIB_W-1:0] SYNC_ERR   = 4'b1010;
    localparam logic [NIB_W-1:0] TURN_NIB   = 4'b1111;

    typedef enum logic [1:0] {
        SP_IO  = 2'd0,
        SP_MEM = 2'd1,
        SP_FW  = 2'd2
    } space_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_SIZE,
        ST_HDATA,
        ST_HTAR1,
        ST_HTAR2,
        ST_SYNC,
        ST_SYNC_END,
        ST_TDATA,
        ST_TTAR1,
        ST_TTAR2
    } tgt_state_t;

endpackage

// File: rtl/lpc_tgt_decode.sv
module lpc_tgt_decode
    import lpc_tgt_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    output logic             start_std_o,
    output logic             fw_rd_o,
    output logic             fw_wr_o,
    output logic             ctype_ok_o,
    output logic             ctype_mem_o,
    output logic             ctype_wr_o,
    output logic             size_ok_o,
    output logic [1:0]       size_code_o
);

    always_comb begin
        start_std_o = (nib_i == START_STD);
        fw_rd_o     = (nib_i == START_FW_RD);
        fw_wr_o     = (nib_i == START_FW_WR);
        // cycle type layout {0, memory, write, 0}
        ctype_ok_o  = (nib_i[3] == 1'b0) && (nib_i[0] == 1'b0);
        ctype_mem_o = nib_i[2];
        ctype_wr_o  = nib_i[1];
        size_ok_o   = (nib_i[3:2] == 2'b00) && (nib_i[1:0] != 2'b11);
        size_code_o = nib_i[1:0];
    end

endmodule

// File: rtl/lpc_tgt_wait_timer.sv
module lpc_tgt_wait_timer #(
    parameter int WAIT_LIMIT = 256,
    parameter int LONG_AFTER = 16,
    parameter int CNT_W      = $clog2(WAIT_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             answered_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o,
    output logic             long_phase_o
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_LIMIT - 1);
    localparam logic [CNT_W-1:0] LONG_CNT = CNT_W'(LONG_AFTER);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q < LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        cnt_o        = cnt_q;
        expired_o    = run_i && !answered_i && (cnt_q == LAST_CNT);
        long_phase_o = (cnt_q >= LONG_CNT);
    end

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
    import lpc_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              start_std_i,
    input  logic              fw_rd_i,
    input  logic              fw_wr_i,
    input  logic              ctype_ok_i,
    input  logic              ctype_mem_i,
    input  logic              ctype_wr_i,
    input  logic              size_ok_i,
    input  logic [1:0]        size_code_i,
    input  logic              expired_i,
    input  logic              long_phase_i,
    input  logic              rsp_ready_i,
    input  logic              rsp_error_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    output tgt_state_t        state_o,
    output logic              sync_run_o,
    output logic [NIB_W-1:0]  bus_out_o,
    output logic              bus_oe_o,
    output logic              req_valid_o,
    output logic              req_write_o,
    output logic [1:0]        req_space_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [1:0]        req_size_o,
    output logic [DATA_W-1:0] req_wdata_o
);

    tgt_state_t        state_q, state_d;
    space_t            space_q;
    logic              write_q;
    logic              err_q;
    logic [1:0]        size_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    logic [IDX_W-1:0]  last_addr_idx;
    logic [IDX_W-1:0]  last_data_idx;
    logic              start_hit;

    always_comb begin
        last_addr_idx = (space_q == SP_IO) ? IDX_W'(3) : IDX_W'(7);
        // 2, 4 or 8 nibbles for size codes 0, 1, 2
        last_data_idx = {size_q == 2'd2, size_q != 2'd0, 1'b1};
        start_hit     = frame_i && (start_std_i || fw_rd_i || fw_wr_i);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q != ST_IDLE && frame_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (frame_i && start_std_i) begin
                        state_d = ST_CTYPE;
                    end else if (frame_i && (fw_rd_i || fw_wr_i)) begin
                        state_d = ST_ADDR;
                    end
                end
                ST_CTYPE: begin
                    state_d = ctype_ok_i ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    if (idx_q == last_addr_idx) begin
                        if (space_q == SP_FW) begin
                            state_d = ST_SIZE;
                        end else begin
                            state_d = write_q ? ST_HDATA : ST_HTAR1;
                        end
                    end
                end
                ST_SIZE: begin
                    if (!size_ok_i) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = write_q ? ST_HDATA : ST_HTAR1;
                    end
                end
                ST_HDATA: begin
                    if (idx_q == last_data_idx) begin
                        state_d = ST_HTAR1;
                    end
                end
                ST_HTAR1: state_d = ST_HTAR2;
                ST_HTAR2: state_d = ST_SYNC;
                ST_SYNC: begin
                    if (rsp_ready_i || expired_i) begin
                        state_d = ST_SYNC_END;
                    end
                end
                ST_SYNC_END: begin
                    state_d = (err_q || write_q) ? ST_TTAR1 : ST_TDATA;
                end
                ST_TDATA: begin
                    if (idx_q == last_data_idx) begin
                        state_d = ST_TTAR1;
                    end
                end
                ST_TTAR1: state_d = ST_TTAR2;
                ST_TTAR2: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // nibble index: advances while a multi-nibble phase continues
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if ((state_q == ST_ADDR || state_q == ST_HDATA ||
                      state_q == ST_TDATA) && state_d == state_q) begin
            idx_q <= idx_q + 1'b1;
        end else begin
            idx_q <= '0;
        end
    end

    // captured cycle fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            space_q <= SP_IO;
            write_q <= 1'b0;
            err_q   <= 1'b0;
            size_q  <= 2'd0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start_hit) begin
                space_q <= start_std_i ? SP_IO : SP_FW;
                write_q <= fw_wr_i;
                err_q   <= 1'b0;
                size_q  <= 2'd0;
                addr_q  <= '0;
                wdata_q <= '0;
            end
            if (state_q == ST_CTYPE) begin
                space_q <= ctype_mem_i ? SP_MEM : SP_IO;
                write_q <= ctype_wr_i;
            end
            if (state_q == ST_ADDR) begin
                addr_q <= {addr_q[ADDR_W-NIB_W-1:0], nib_i};
            end
            if (state_q == ST_SIZE) begin
                size_q <= size_code_i;
            end
            if (state_q == ST_HDATA) begin
                wdata_q[{idx_q, 2'b00} +: NIB_W] <= nib_i;
            end
            if (state_q == ST_SYNC && !frame_i) begin
                if (rsp_ready_i) begin
                    err_q   <= rsp_error_i;
                    rdata_q <= rsp_rdata_i;
                end else if (expired_i) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        state_o     = state_q;
        sync_run_o  = (state_q == ST_SYNC);
        req_valid_o = (state_q == ST_SYNC);
        req_write_o = write_q;
        req_space_o = space_q;
        req_addr_o  = addr_q;
        req_size_o  = size_q;
        req_wdata_o = wdata_q;
        bus_oe_o    = 1'b0;
        bus_out_o   = '0;
        unique case (state_q)
            ST_SYNC: begin
                bus_oe_o  = 1'b1;
                bus_out_o = long_phase_i ? SYNC_LONG : SYNC_SHORT;
            end
            ST_SYNC_END: begin
                bus_oe_o  = 1'b1;
                bus_out_o = err_q ? SYNC_ERR : SYNC_READY;
            end
            ST_TDATA: begin
                bus_oe_o  = 1'b1;
                bus_out_o = rdata_q[{idx_q, 2'b00} +: NIB_W];
            end
            ST_TTAR1: begin
                bus_oe_o  = 1'b1;
                bus_out_o = TURN_NIB;
            end
            default: begin
                bus_oe_o  = 1'b0;
                bus_out_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_target_bridge.sv
module lpc_target_bridge
    import lpc_tgt_pkg::*;
#(
    parameter int WAIT_LIMIT = 256,
    parameter int LONG_AFTER = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_i,
    input  logic [3:0]  bus_in,
    output logic [3:0]  bus_out,
    output logic        bus_oe,
    output logic        req_valid,
    output logic        req_write,
    output logic [1:0]  req_space,
    output logic [31:0] req_addr,
    output logic [1:0]  req_size,
    output logic [31:0] req_wdata,
    input  logic        rsp_ready,
    input  logic        rsp_error,
    input  logic [31:0] rsp_rdata
);

    localparam int CNT_W = $clog2(WAIT_LIMIT + 1);

    logic             start_std_w, fw_rd_w, fw_wr_w;
    logic             ctype_ok_w, ctype_mem_w, ctype_wr_w;
    logic             size_ok_w;
    logic [1:0]       size_code_w;
    logic             expired_w, long_phase_w, sync_run_w;
    logic [CNT_W-1:0] wait_cnt_w;
    tgt_state_t       state_w;

    lpc_tgt_decode u_decode (
        .nib_i       (bus_in),
        .start_std_o (start_std_w),
        .fw_rd_o     (fw_rd_w),
        .fw_wr_o     (fw_wr_w),
        .ctype_ok_o  (ctype_ok_w),
        .ctype_mem_o (ctype_mem_w),
        .ctype_wr_o  (ctype_wr_w),
        .size_ok_o   (size_ok_w),
        .size_code_o (size_code_w)
    );

    lpc_tgt_wait_timer #(
        .WAIT_LIMIT (WAIT_LIMIT),
        .LONG_AFTER (LONG_AFTER),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (sync_run_w),
        .answered_i   (rsp_ready),
        .cnt_o        (wait_cnt_w),
        .expired_o    (expired_w),
        .long_phase_o (long_phase_w)
    );

    lpc_tgt_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_i      (frame_i),
        .nib_i        (bus_in),
        .start_std_i  (start_std_w),
        .fw_rd_i      (fw_rd_w),
        .fw_wr_i      (fw_wr_w),
        .ctype_ok_i   (ctype_ok_w),
        .ctype_mem_i  (ctype_mem_w),
        .ctype_wr_i   (ctype_wr_w),
        .size_ok_i    (size_ok_w),
        .size_code_i  (size_code_w),
        .expired_i    (expired_w),
        .long_phase_i (long_phase_w),
        .rsp_ready_i  (rsp_ready),
        .rsp_error_i  (rsp_error),
        .rsp_rdata_i  (rsp_rdata),
        .state_o      (state_w),
        .sync_run_o   (sync_run_w),
        .bus_out_o    (bus_out),
        .bus_oe_o     (bus_oe),
        .req_valid_o  (req_valid),
        .req_write_o  (req_write),
        .req_space_o  (req_space),
        .req_addr_o   (req_addr),
        .req_size_o   (req_size),
        .req_wdata_o  (req_wdata)
    );

endmodule

// File: rtl/lpc_tgt_checker.sv
module lpc_tgt_checker
    import lpc_tgt_pkg::*;
#(
    parameter int WAIT_LIMIT = 256,
    parameter int CNT_W      = $clog2(WAIT_LIMIT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_i,
    input logic [3:0]       bus_out,
    input logic             bus_oe,
    input logic             req_valid,
    input logic             req_write,
    input logic [31:0]      req_addr,
    input logic             rsp_ready,
    input tgt_state_t       state,
    input logic             expired,
    input logic [CNT_W-1:0] wait_cnt
);

    // R6: drive only in target phases
    p_oe_target_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (state == ST_SYNC || state == ST_SYNC_END ||
                    state == ST_TDATA || state == ST_TTAR1));

    // R8: an outstanding request is accompanied by a wait code
    p_wait_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (bus_oe && (bus_out == SYNC_SHORT || bus_out == SYNC_LONG)));

    // R7: unanswered request holds its fields
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_ready && !expired && !frame_i) |=>
            (req_valid && $stable(req_addr) && $stable(req_write)));

    // R8/R10: request ends with a ready or error code
    p_end_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_valid) && !$past(frame_i)) |->
            (bus_oe && (bus_out == SYNC_READY || bus_out == SYNC_ERR)));

    // R9: error code goes straight to turnaround
    p_err_turn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC_END && bus_out == SYNC_ERR && !frame_i) |=>
            (bus_oe && bus_out == TURN_NIB));

    // R12: turnaround nibble then release
    p_turn_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TTAR1 && !frame_i) |=> !bus_oe);

    // R13: frame releases bus and request next clock
    p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (!bus_oe && !req_valid));

    // R10: wait window bounded by the limit
    p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < CNT_W'(WAIT_LIMIT));

endmodule

bind lpc_target_bridge lpc_tgt_checker #(
    .WAIT_LIMIT (WAIT_LIMIT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_i   (frame_i),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_ready (rsp_ready),
    .state     (state_w),
    .expired   (expired_w),
    .wait_cnt  (wait_cnt_w)
);

// File: tb/tb_lpc_target_bridge.sv
`timescale 1ns/1ps
module tb_lpc_target_bridge;

    localparam int WL = 12;
    localparam int LA = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_i = 1'b0;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        req_valid, req_write;
    logic [1:0]  req_space, req_size;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_ready = 1'b0;
    logic        rsp_error = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lpc_target_bridge #(.WAIT_LIMIT(WL), .LONG_AFTER(LA)) dut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .req_valid(req_valid),
        .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
        .rsp_error(rsp_error), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // host drives one nibble; bus must be free during host phases
    task automatic drive(input logic f, input logic [3:0] n);
        chk("R6 no target drive in host phase", 32'(bus_oe), 32'd0);
        frame_i = f;
        bus_in  = n;
        @(negedge clk);
        frame_i = 1'b0;
    endtask

    task automatic idle_checks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(1'b0, 4'hF);
            chk(tag, 32'(req_valid), 32'd0);
        end
    endtask

    task automatic host_header(input int sp, input bit wr, input logic [31:0] a,
                               input int szc, input logic [31:0] wd);
        int an = (sp == 0) ? 4 : 8;
        int dn = 2 << szc;
        if (sp == 2) drive(1'b1, wr ? 4'b1110 : 4'b1101);
        else begin
            drive(1'b1, 4'b0000);
            drive(1'b0, {1'b0, sp == 1, wr, 1'b0});
        end
        for (int i = 0; i < an; i++) drive(1'b0, a[(an-1-i)*4 +: 4]);
        if (sp == 2) drive(1'b0, 4'(szc));
        if (wr) for (int i = 0; i < dn; i++) drive(1'b0, wd[i*4 +: 4]);
        drive(1'b0, 4'hF);
        drive(1'b0, 4'hF);
    endtask

    function automatic logic [3:0] wait_code(input int k);
        return (k < LA) ? 4'b0101 : 4'b0110;
    endfunction

    task automatic run_cycle(input int sp, input bit wr, input logic [31:0] a, input int szc,
                             input logic [31:0] wd, input int waits, input bit err,
                             input logic [31:0] rd, input bit tmo);
        int dn = 2 << szc;
        logic [31:0] mask = (dn == 8) ? 32'hFFFF_FFFF : ((32'h1 << (dn*4)) - 1);
        host_header(sp, wr, a, szc, wd);
        chk("R7 req_valid in sync", 32'(req_valid), 32'd1);
        chk("R1 req_space", 32'(req_space), 32'(sp));
        chk("R2 req_write", 32'(req_write), 32'(wr));
        chk("R3 req_addr", req_addr, (sp == 0) ? {16'h0, a[15:0]} : a);
        chk("R4 req_size", 32'(req_size), 32'(szc));
        chk("R5 req_wdata", req_wdata, wr ? (wd & mask) : 32'h0);
        if (tmo) begin
            for (int k = 0; k < WL; k++) begin
                chk("R8 wait code", 32'(bus_out), 32'(wait_code(k)));
                chk("R7 req held", 32'(req_valid), 32'd1);
                @(negedge clk);
            end
            chk("R10 timeout error code", 32'(bus_out), 32'hA);
            chk("R10 request withdrawn", 32'(req_valid), 32'd0);
        end else begin
            for (int k = 0; k < waits; k++) begin
                chk("R8 wait code", 32'(bus_out), 32'(wait_code(k)));
                @(negedge clk);
                chk("R7 req held", 32'(req_valid), 32'd1);
            end
            chk("R8 wait code", 32'(bus_out), 32'(wait_code(waits)));
            rsp_ready = 1'b1; rsp_error = err; rsp_rdata = rd;
            @(negedge clk);
            rsp_ready = 1'b0; rsp_error = 1'b0;
            chk(err ? "R9 error code" : "R8 ready code", 32'(bus_out), err ? 32'hA : 32'h0);
            chk("R7 req dropped", 32'(req_valid), 32'd0);
        end
        if (!wr && !err && !tmo) begin
            for (int i = 0; i < dn; i++) begin
                @(negedge clk);
                chk("R11 read nibble", {27'h0, bus_oe, bus_out}, {27'h0, 1'b1, rd[i*4 +: 4]});
            end
        end
        @(negedge clk);
        chk((err || tmo) ? "R9 turnaround after error" : "R12 turnaround drive",
            {27'h0, bus_oe, bus_out}, 32'h1F);
        @(negedge clk);
        chk("R12 released", 32'(bus_oe), 32'd0);
        @(negedge clk);
        chk("R12 idle", {30'h0, bus_oe, req_valid}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R12 reset oe", 32'(bus_oe), 32'd0);
        chk("R7 reset req", 32'(req_valid), 32'd0);
    endtask

    task automatic t_io;
        run_cycle(0, 1'b1, 32'hDEAD_3F8A, 0, 32'h0000_005C, 0, 1'b0, 32'h0, 1'b0);
        run_cycle(0, 1'b0, 32'h0000_0C41, 0, 32'h0, 1, 1'b0, 32'h0000_00B7, 1'b0);
    endtask

    task automatic t_mem;
        run_cycle(1, 1'b1, 32'hFEC0_1234, 0, 32'h0000_00A5, 2, 1'b0, 32'h0, 1'b0);
        run_cycle(1, 1'b0, 32'h89AB_CDEF, 0, 32'h0, 3, 1'b0, 32'h0000_003E, 1'b0);
    endtask

    task automatic t_fw;
        run_cycle(2, 1'b0, 32'h5FFF_0010, 0, 32'h0, 0, 1'b0, 32'h0000_0069, 1'b0);
        run_cycle(2, 1'b0, 32'h1234_5678, 1, 32'h0, 1, 1'b0, 32'h0000_BEEF, 1'b0);
        run_cycle(2, 1'b0, 32'hA000_0004, 2, 32'h0, 0, 1'b0, 32'hC0DE_F00D, 1'b0);
        run_cycle(2, 1'b1, 32'h7654_3210, 2, 32'h1357_9BDF, 2, 1'b0, 32'h0, 1'b0);
        run_cycle(2, 1'b1, 32'h0000_0100, 1, 32'hFFFF_4321, 0, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic t_long_wait;
        run_cycle(1, 1'b0, 32'h0000_0040, 0, 32'h0, 7, 1'b0, 32'h0000_0091, 1'b0);
    endtask

    task automatic t_errors;
        run_cycle(2, 1'b0, 32'h0100_0000, 2, 32'h0, 1, 1'b1, 32'h1111_2222, 1'b0);
        run_cycle(0, 1'b1, 32'h0000_0080, 0, 32'h0000_0077, 0, 1'b1, 32'h0, 1'b0);
        run_cycle(1, 1'b0, 32'h0BAD_0000, 0, 32'h0, 0, 1'b0, 32'h0, 1'b1);
    endtask

    task automatic t_ignored;
        drive(1'b1, 4'b0011);
        idle_checks(3, "R1 bad start ignored");
        drive(1'b1, 4'b0000);
        drive(1'b0, 4'b1000);
        idle_checks(8, "R2 bad cycle type ignored");
        drive(1'b1, 4'b1101);
        for (int i = 0; i < 8; i++) drive(1'b0, 4'h2);
        drive(1'b0, 4'h3);
        idle_checks(8, "R4 bad size ignored");
        run_cycle(0, 1'b0, 32'h0000_0060, 0, 32'h0, 0, 1'b0, 32'h0000_0042, 1'b0);
    endtask

    task automatic t_abort;
        drive(1'b1, 4'b0000);
        drive(1'b0, 4'b0010);
        drive(1'b0, 4'h1);
        drive(1'b0, 4'h2);
        drive(1'b1, 4'hF);
        idle_checks(8, "R13 abort in address");
        host_header(0, 1'b0, 32'h0000_0070, 0, 32'h0);
        chk("R7 req up before abort", 32'(req_valid), 32'd1);
        frame_i = 1'b1; bus_in = 4'hF;
        @(negedge clk);
        frame_i = 1'b0;
        chk("R13 abort releases bus", {30'h0, bus_oe, req_valid}, 32'd0);
        idle_checks(3, "R13 idle after abort");
        run_cycle(1, 1'b1, 32'h2222_3333, 0, 32'h0000_00E1, 0, 1'b0, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_io();
        t_mem();
        t_fw();
        t_long_wait();
        t_errors();
        t_ignored();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule